// File: doc/BRIEF.md
# Link Management Register File

This block is a byte-wide register file through which a host configures and monitors a 1000BASE-X-style PCS link. Each 16-bit management register is split into a low byte at an even address and a high byte at the following odd address. It covers the control register, the status register, the advertised and partner abilities, negotiation expansion and extended status. The host runs a simple selection handshake: chip select and write strobe are active low, there is a 6-bit byte address, and an active-low ready reports completion.

The control fields are driven out as level signals to the rest of the PCS: loopback, negotiation enable, isolate and unidirectional mode. Reset and negotiation restart leave the block as one-cycle pulses. Link state, negotiation completion, page arrival and the partner's ability word come in as inputs. Link status is held low after the link drops until the host reads it. The page-received flag is held high until the host reads it. The negotiation engine is not part of the block.

Top module: `mgmt_link_regs`

## Requirements
- R1: One access takes place per selection. `rdy_n` goes low one clock after `cs_n` is first sampled low, and returns high one clock after `cs_n` is sampled high. A write lands on that first edge, and later data while selection is held has no effect.
- R2: Control-high byte (address 0x01) reads {reset, loopback, 0, neg-enable, power-down, isolate, restart, duplex} from bit 7 down to bit 0. Bit 5 is always 0. After reset it reads 0x11.
- R3: Writing 1 to control-high bit 7 gives `pcs_reset` a one-cycle pulse, and writing 1 to bit 1 gives `an_restart` a one-cycle pulse. Both pulses fall in the clock after the write, and both bits read back as 0.
- R4: Control-low byte (address 0x00) reads 0x40 OR (unidir << 5). Only bit 5 is writable, and its reset value is 0.
- R5: Advertised ability is a writable 16-bit word, low byte at 0x08 and high byte at 0x09. It resets to 0x0020.
- R6: Status-low byte (0x02) is {1, 0, an_done, 0, 1, link, 0, 0} from bit 7 down to bit 0. Status-high byte (0x03) reads 0x01.
- R7: Link status (0x02 bit 2) clears to 0 whenever `link_ok` is low and stays 0 until a completed read of address 0x02. After that read it follows `link_ok`. It is 0 after reset.
- R8: Page received (0x0C bit 1) is set by `page_rx` and cleared only by a completed read of address 0x0C. A `page_rx` in the clock of that read keeps the flag set. All other bits of 0x0C and all of 0x0D read 0.
- R9: Addresses 0x0A and 0x0B return the live `lp_ability` low and high bytes.
- R10: Extended status reads 0x00 at 0x1E and 0x80 at 0x1F.
- R11: Reads of unmapped addresses return 0x00. Writes to read-only or fixed bits change nothing.
- R12: `loopback_en`, `an_enable`, `isolate_en` and `unidir_en` follow the stored control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host clock; all logic on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low; high selects a read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rdy_n` is low after a read |
| rdy_n | output | 1 | Access complete, active low |
| link_ok | input | 1 | Current link state |
| an_done | input | 1 | Negotiation complete |
| page_rx | input | 1 | Page-received event |
| lp_ability | input | 16 | Link partner ability word |
| pcs_reset | output | 1 | One-cycle PCS reset pulse |
| loopback_en | output | 1 | Loopback enable |
| an_enable | output | 1 | Negotiation enable |
| an_restart | output | 1 | One-cycle negotiation restart pulse |
| isolate_en | output | 1 | Isolate enable |
| unidir_en | output | 1 | Unidirectional mode enable |

## Verification
The bench builds the block with its defaults: a 6-bit address, advertised reset value 0x0020 and unidirectional capability set. With a 6-bit address the whole map fits in 64 locations. Every one of them is read after reset, written with all-ones and all-zeros, and read again. It also makes every value of both control bytes reachable in a full 256-value sweep. The latched flags are exercised against drops, events that coincide with the read, and reads of the neighbouring byte.

// File: rtl/mgmt_link_regs_pkg.sv
// Package: shared constants and field type for the link management register file.
// Assumes byte-wide data; register offsets are those the host decodes.
package mgmt_link_regs_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 2 * BYTE_W;

    // byte addresses decoded by the host
    localparam int unsigned ADR_CTRL_LO = 'h00;
    localparam int unsigned ADR_CTRL_HI = 'h01;
    localparam int unsigned ADR_STAT_LO = 'h02;
    localparam int unsigned ADR_STAT_HI = 'h03;
    localparam int unsigned ADR_ADV_LO  = 'h08;
    localparam int unsigned ADR_ADV_HI  = 'h09;
    localparam int unsigned ADR_LP_LO   = 'h0A;
    localparam int unsigned ADR_LP_HI   = 'h0B;
    localparam int unsigned ADR_EXP_LO  = 'h0C;
    localparam int unsigned ADR_EXP_HI  = 'h0D;
    localparam int unsigned ADR_EXT_LO  = 'h1E;
    localparam int unsigned ADR_EXT_HI  = 'h1F;

    // fixed read values
    localparam logic [BYTE_W-1:0] STAT_HI_VAL = 8'h01;
    localparam logic [BYTE_W-1:0] EXT_HI_VAL  = 8'h80;
    localparam logic [BYTE_W-1:0] EXT_LO_VAL  = 8'h00;

    // stored control fields
    typedef struct packed {
        logic loopback;
        logic an_enable;
        logic power_down;
        logic isolate;
        logic duplex;
        logic unidir;
    } ctrl_fields_t;

endpackage

// File: rtl/mgmt_host_if.sv
// Module: host handshake for the register file.
// Produces one write or read strobe per selection and the active-low ready.
// Assumes the host deselects for at least one clock between accesses.
module mgmt_host_if (
    input  logic host_clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic we_n,
    output logic rdy_n,
    output logic wr_stb,
    output logic rd_stb
);

    logic first_cycle;

    // an access is taken only on the first selected clock (ready still high)
    assign first_cycle = !cs_n && rdy_n;
    assign wr_stb      = first_cycle && !we_n;
    assign rd_stb      = first_cycle && we_n;

    // ready follows selection one clock later and clears on deselection
    always_ff @(posedge host_clk) begin
        if (!rst_n) begin
            rdy_n <= 1'b1;
        end else begin
            rdy_n <= cs_n;
        end
    end

endmodule

// File: rtl/mgmt_ctrl_regs.sv
// Module: writable control and advertised-ability storage.
// Holds the control fields and the 16-bit ability word, and makes the
// self-clearing reset and restart bits one-cycle pulses.
// Assumes wr_stb lasts one clock per access.
module mgmt_ctrl_regs
    import mgmt_link_regs_pkg::*;
#(
    parameter int unsigned      ADDR_W    = 6,
    parameter logic [WORD_W-1:0] ADV_RESET = 16'h0020
) (
    input  logic               host_clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BYTE_W-1:0]  wdata,
    output ctrl_fields_t       ctrl,
    output logic               rst_pulse,
    output logic               restart_pulse,
    output logic [WORD_W-1:0]  adv
);

    localparam logic [ADDR_W-1:0] A_CLO = ADDR_W'(ADR_CTRL_LO);
    localparam logic [ADDR_W-1:0] A_CHI = ADDR_W'(ADR_CTRL_HI);
    localparam logic [ADDR_W-1:0] A_ALO = ADDR_W'(ADR_ADV_LO);
    localparam logic [ADDR_W-1:0] A_AHI = ADDR_W'(ADR_ADV_HI);

    // control fields: masked byte writes; fixed bits are never stored
    always_ff @(posedge host_clk) begin
        if (!rst_n) begin
            ctrl <= '{loopback: 1'b0, an_enable: 1'b1, power_down: 1'b0,
                      isolate: 1'b0, duplex: 1'b1, unidir: 1'b0};
        end else if (wr_stb) begin
            if (addr == A_CHI) begin
                ctrl.loopback   <= wdata[6];
                ctrl.an_enable  <= wdata[4];
                ctrl.power_down <= wdata[3];
                ctrl.isolate    <= wdata[2];
                ctrl.duplex     <= wdata[0];
            end
            if (addr == A_CLO) begin
                ctrl.unidir <= wdata[5];
            end
        end
    end

    // self-clearing command bits: set by a write of 1, gone one clock later
    always_ff @(posedge host_clk) begin
        if (!rst_n) begin
            rst_pulse     <= 1'b0;
            restart_pulse <= 1'b0;
        end else begin
            rst_pulse     <= wr_stb && (addr == A_CHI) && wdata[7];
            restart_pulse <= wr_stb && (addr == A_CHI) && wdata[1];
        end
    end

    // advertised ability word: two independently written bytes
    always_ff @(posedge host_clk) begin
        if (!rst_n) begin
            adv <= ADV_RESET;
        end else if (wr_stb) begin
            if (addr == A_ALO) adv[BYTE_W-1:0]      <= wdata;
            if (addr == A_AHI) adv[WORD_W-1:BYTE_W] <= wdata;
        end
    end

endmodule

// File: rtl/mgmt_status_latch.sv
// Module: latched status flags.
// Link status latches low on any drop and is refreshed by a read of its byte.
// Page received latches high and is cleared by a read of its byte; a new event
// in the clock of that read wins.
module mgmt_status_latch
    import mgmt_link_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              host_clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic              link_ok,
    input  logic              page_rx,
    output logic              link_lat,
    output logic              page_lat
);

    localparam logic [ADDR_W-1:0] A_SLO = ADDR_W'(ADR_STAT_LO);
    localparam logic [ADDR_W-1:0] A_ELO = ADDR_W'(ADR_EXP_LO);

    logic rd_link;
    logic rd_page;

    assign rd_link = rd_stb && (addr == A_SLO);
    assign rd_page = rd_stb && (addr == A_ELO);

    // latch-low link status, refreshed to the live state on its read
    always_ff @(posedge host_clk) begin
        if (!rst_n) begin
            link_lat <= 1'b0;
        end else if (rd_link) begin
            link_lat <= link_ok;
        end else begin
            link_lat <= link_lat && link_ok;
        end
    end

    // latch-high page flag, cleared on its read unless a new event arrives
    always_ff @(posedge host_clk) begin
        if (!rst_n) begin
            page_lat <= 1'b0;
        end else begin
            page_lat <= page_rx || (page_lat && !rd_page);
        end
    end

endmodule

// File: rtl/mgmt_link_regs.sv
// Module: top of the byte-wide link management register file.
// Decodes host accesses, stores control state, latches status flags and
// returns the addressed byte one clock after selection.
// Assumes a single host clock domain for all inputs.
module mgmt_link_regs
    import mgmt_link_regs_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 6,
    parameter logic [WORD_W-1:0] ADV_RESET   = 16'h0020,
    parameter logic              UNIDIR_ABLE = 1'b1
) (
    input  logic              host_clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rdy_n,
    input  logic              link_ok,
    input  logic              an_done,
    input  logic              page_rx,
    input  logic [15:0]       lp_ability,
    output logic              pcs_reset,
    output logic              loopback_en,
    output logic              an_enable,
    output logic              an_restart,
    output logic              isolate_en,
    output logic              unidir_en
);

    localparam logic [ADDR_W-1:0] A_CLO = ADDR_W'(ADR_CTRL_LO);
    localparam logic [ADDR_W-1:0] A_CHI = ADDR_W'(ADR_CTRL_HI);
    localparam logic [ADDR_W-1:0] A_SLO = ADDR_W'(ADR_STAT_LO);
    localparam logic [ADDR_W-1:0] A_SHI = ADDR_W'(ADR_STAT_HI);
    localparam logic [ADDR_W-1:0] A_ALO = ADDR_W'(ADR_ADV_LO);
    localparam logic [ADDR_W-1:0] A_AHI = ADDR_W'(ADR_ADV_HI);
    localparam logic [ADDR_W-1:0] A_LLO = ADDR_W'(ADR_LP_LO);
    localparam logic [ADDR_W-1:0] A_LHI = ADDR_W'(ADR_LP_HI);
    localparam logic [ADDR_W-1:0] A_ELO = ADDR_W'(ADR_EXP_LO);
    localparam logic [ADDR_W-1:0] A_EHI = ADDR_W'(ADR_EXP_HI);
    localparam logic [ADDR_W-1:0] A_XLO = ADDR_W'(ADR_EXT_LO);
    localparam logic [ADDR_W-1:0] A_XHI = ADDR_W'(ADR_EXT_HI);

    logic              wr_stb;
    logic              rd_stb;
    ctrl_fields_t      ctrl;
    logic [WORD_W-1:0] adv;
    logic              link_lat;
    logic              page_lat;
    logic [BYTE_W-1:0] rd_mux;

    mgmt_host_if u_host (
        .host_clk (host_clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .rdy_n    (rdy_n),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb)
    );

    mgmt_ctrl_regs #(
        .ADDR_W    (ADDR_W),
        .ADV_RESET (ADV_RESET)
    ) u_ctrl (
        .host_clk      (host_clk),
        .rst_n         (rst_n),
        .wr_stb        (wr_stb),
        .addr          (addr),
        .wdata         (wdata),
        .ctrl          (ctrl),
        .rst_pulse     (pcs_reset),
        .restart_pulse (an_restart),
        .adv           (adv)
    );

    mgmt_status_latch #(
        .ADDR_W (ADDR_W)
    ) u_stat (
        .host_clk (host_clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .addr     (addr),
        .link_ok  (link_ok),
        .page_rx  (page_rx),
        .link_lat (link_lat),
        .page_lat (page_lat)
    );

    assign loopback_en = ctrl.loopback;
    assign an_enable   = ctrl.an_enable;
    assign isolate_en  = ctrl.isolate;
    assign unidir_en   = ctrl.unidir;

    // read multiplexer: assembles the addressed byte with its fixed bits
    always_comb begin
        rd_mux = '0;
        case (addr)
            A_CLO: rd_mux = {1'b0, 1'b1, ctrl.unidir, 5'b0};
            A_CHI: rd_mux = {pcs_reset, ctrl.loopback, 1'b0, ctrl.an_enable,
                             ctrl.power_down, ctrl.isolate, an_restart, ctrl.duplex};
            A_SLO: rd_mux = {UNIDIR_ABLE, 1'b0, an_done, 1'b0, 1'b1, link_lat, 2'b0};
            A_SHI: rd_mux = STAT_HI_VAL;
            A_ALO: rd_mux = adv[BYTE_W-1:0];
            A_AHI: rd_mux = adv[WORD_W-1:BYTE_W];
            A_LLO: rd_mux = lp_ability[BYTE_W-1:0];
            A_LHI: rd_mux = lp_ability[WORD_W-1:BYTE_W];
            A_ELO: rd_mux = {5'b0, 1'b0, page_lat, 1'b0};
            A_EHI: rd_mux = '0;
            A_XLO: rd_mux = EXT_LO_VAL;
            A_XHI: rd_mux = EXT_HI_VAL;
            default: rd_mux = '0;
        endcase
    end

    // read data register: captured on the read strobe, held otherwise
    always_ff @(posedge host_clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_stb) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/mgmt_link_regs_chk.sv
// Module: property checker bound to the register file top.
// Observes the handshake, the command pulses and the latched flags.
module mgmt_link_regs_chk (
    input logic       host_clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rdy_n,
    input logic [7:0] rdata,
    input logic       pcs_reset,
    input logic       an_restart,
    input logic       link_ok,
    input logic       link_lat,
    input logic       page_rx,
    input logic       page_lat
);

    // R1
    ready_release_chk: assert property (@(posedge host_clk) disable iff (!rst_n)
        cs_n |=> rdy_n);

    // R1
    ready_assert_chk: assert property (@(posedge host_clk) disable iff (!rst_n)
        (!cs_n && rdy_n) |=> !rdy_n);

    // R1
    rdata_hold_chk: assert property (@(posedge host_clk) disable iff (!rst_n)
        cs_n |=> $stable(rdata));

    // R3
    reset_pulse_chk: assert property (@(posedge host_clk) disable iff (!rst_n)
        pcs_reset |=> !pcs_reset);

    // R3
    restart_pulse_chk: assert property (@(posedge host_clk) disable iff (!rst_n)
        an_restart |=> !an_restart);

    // R7
    link_drop_chk: assert property (@(posedge host_clk) disable iff (!rst_n)
        !link_ok |=> !link_lat);

    // R8
    page_set_chk: assert property (@(posedge host_clk) disable iff (!rst_n)
        page_rx |=> page_lat);

endmodule

bind mgmt_link_regs mgmt_link_regs_chk u_chk (
    .host_clk   (host_clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .rdy_n      (rdy_n),
    .rdata      (rdata),
    .pcs_reset  (pcs_reset),
    .an_restart (an_restart),
    .link_ok    (link_ok),
    .link_lat   (link_lat),
    .page_rx    (page_rx),
    .page_lat   (page_lat)
);

// File: tb/mgmt_link_regs_bench.sv
// Bench: near-exhaustive sweeps of the register file against a bench model.
module mgmt_link_regs_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        we_n = 1'b1;
    logic [5:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdy_n;
    logic        lnk = 1'b1;
    logic        and_in = 1'b0;
    logic        prx = 1'b0;
    logic [15:0] lp = 16'h0000;
    logic        pcs_reset, loopback_en, an_enable, an_restart, isolate_en, unidir_en;

    int total = 0;
    int fails = 0;

    // bench model of stored state
    logic        m_lb = 1'b0, m_an = 1'b1, m_pd = 1'b0, m_iso = 1'b0, m_dup = 1'b1, m_uni = 1'b0;
    logic [15:0] m_adv = 16'h0020;
    logic        m_link = 1'b0, m_page = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mgmt_link_regs u_mgmt_link_regs (
        .host_clk (clk), .rst_n (rst_n), .cs_n (cs_n), .we_n (we_n),
        .addr (addr), .wdata (wdata), .rdata (rdata), .rdy_n (rdy_n),
        .link_ok (lnk), .an_done (and_in), .page_rx (prx), .lp_ability (lp),
        .pcs_reset (pcs_reset), .loopback_en (loopback_en), .an_enable (an_enable),
        .an_restart (an_restart), .isolate_en (isolate_en), .unidir_en (unidir_en)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [5:0] a);
        case (a)
            6'h00: return "R4";
            6'h01: return "R2";
            6'h02, 6'h03: return "R6";
            6'h08, 6'h09: return "R5";
            6'h0A, 6'h0B: return "R9";
            6'h0C, 6'h0D: return "R8";
            6'h1E, 6'h1F: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic [5:0] a);
        case (a)
            6'h00: return {1'b0, 1'b1, m_uni, 5'b0};
            6'h01: return {1'b0, m_lb, 1'b0, m_an, m_pd, m_iso, 1'b0, m_dup};
            6'h02: return {1'b1, 1'b0, and_in, 1'b0, 1'b1, m_link, 2'b0};
            6'h03: return 8'h01;
            6'h08: return m_adv[7:0];
            6'h09: return m_adv[15:8];
            6'h0A: return lp[7:0];
            6'h0B: return lp[15:8];
            6'h0C: return {6'b0, m_page, 1'b0};
            6'h1F: return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk_outs();
        chk("R12 loopback", 16'(loopback_en), 16'(m_lb));
        chk("R12 an_enable", 16'(an_enable), 16'(m_an));
        chk("R12 isolate", 16'(isolate_en), 16'(m_iso));
        chk("R12 unidir", 16'(unidir_en), 16'(m_uni));
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        chk("R1 idle ready", 16'(rdy_n), 16'd1);
        cs_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        chk("R1 write ready", 16'(rdy_n), 16'd0);
        chk("R3 reset pulse", 16'(pcs_reset), 16'((a == 6'h01) && d[7]));
        chk("R3 restart pulse", 16'(an_restart), 16'((a == 6'h01) && d[1]));
        if (a == 6'h01) begin
            m_lb = d[6]; m_an = d[4]; m_pd = d[3]; m_iso = d[2]; m_dup = d[0];
        end
        if (a == 6'h00) m_uni = d[5];
        if (a == 6'h08) m_adv[7:0] = d;
        if (a == 6'h09) m_adv[15:8] = d;
        cs_n = 1'b1; we_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 release ready", 16'(rdy_n), 16'd1);
        chk("R3 reset cleared", 16'(pcs_reset), 16'd0);
        chk("R3 restart cleared", 16'(an_restart), 16'd0);
    endtask

    task automatic rd(input logic [5:0] a);
        logic [7:0] e;
        @(negedge clk);
        e = exp_rd(a);
        cs_n = 1'b0; we_n = 1'b1; addr = a;
        @(posedge clk); @(negedge clk);
        chk("R1 read ready", 16'(rdy_n), 16'd0);
        chk(tag_of(a), 16'(rdata), 16'(e));
        if (a == 6'h02) m_link = lnk;
        if (a == 6'h0C) m_page = prx;
        cs_n = 1'b1;
        @(posedge clk);
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_P * 150000);
        total++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R2, R4, R5, R12)
        chk("R1 reset ready", 16'(rdy_n), 16'd1);
        chk("R3 reset idle", 16'(pcs_reset), 16'd0);
        chk_outs();
        for (int a = 0; a < 64; a++) rd(6'(a));

        // all-ones and all-zeros writes to every address (R11)
        for (int a = 0; a < 64; a++) wr(6'(a), 8'hFF);
        chk_outs();
        for (int a = 0; a < 64; a++) rd(6'(a));
        for (int a = 0; a < 64; a++) wr(6'(a), 8'h00);
        for (int a = 0; a < 64; a++) rd(6'(a));

        // full control-byte sweeps (R2, R4, R12)
        for (int v = 0; v < 256; v++) begin
            wr(6'h01, 8'(v));
            chk_outs();
            rd(6'h01);
        end
        for (int v = 0; v < 256; v++) begin
            wr(6'h00, 8'(v));
            chk_outs();
            rd(6'h00);
        end

        // advertised ability walking bits (R5)
        for (int i = 0; i < 16; i++) begin
            logic [15:0] w;
            w = 16'h1 << i;
            wr(6'h08, w[7:0]);
            wr(6'h09, w[15:8]);
            rd(6'h08);
            rd(6'h09);
        end

        // partner ability live values (R9)
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            lp = (16'h1 << i) ^ 16'hA5C3;
            rd(6'h0A);
            rd(6'h0B);
        end

        // negotiation complete follows input (R6)
        @(negedge clk); and_in = 1'b1; rd(6'h02);
        @(negedge clk); and_in = 1'b0; rd(6'h02);

        // R1: held selection with changing data performs one write only
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b0; addr = 6'h08; wdata = 8'h3C;
        @(posedge clk); @(negedge clk);
        wdata = 8'hC3;
        repeat (3) @(negedge clk);
        chk("R1 held ready", 16'(rdy_n), 16'd0);
        cs_n = 1'b1; we_n = 1'b1;
        m_adv[7:0] = 8'h3C;
        @(posedge clk);
        rd(6'h08);

        // R7: link drop latches, neighbouring read does not refresh
        rd(6'h02);
        rd(6'h02);
        @(negedge clk); lnk = 1'b0;
        @(negedge clk); @(negedge clk); lnk = 1'b1; m_link = 1'b0;
        rd(6'h03);
        rd(6'h02);
        chk("R7 refreshed model", 16'(m_link), 16'd1);
        rd(6'h02);
        @(negedge clk); lnk = 1'b0;
        @(negedge clk); m_link = 1'b0;
        rd(6'h02);
        rd(6'h02);
        @(negedge clk); lnk = 1'b1;
        rd(6'h02);
        rd(6'h02);

        // R8: page latch, neighbour read, clear on read, coincident event
        @(negedge clk); prx = 1'b1;
        @(negedge clk); prx = 1'b0; m_page = 1'b1;
        rd(6'h0D);
        rd(6'h0C);
        rd(6'h0C);
        @(negedge clk); prx = 1'b1;
        @(negedge clk); m_page = 1'b1;
        rd(6'h0C);
        @(negedge clk); prx = 1'b0;
        rd(6'h0C);
        rd(6'h0C);

        summary();
        $finish;
    end

endmodule